// File: doc/BRIEF.md
# FIQ/IRQ Prioritizing Interrupt Controller

This block collects up to 32 interrupt lines and drives two processor request outputs: a fast request and a normal request. Each line is latched into a pending register, either from its hardware input or from a software write that sets pending bits. A per-line configuration word gives the line a priority, routes it to the fast or the normal output, and picks edge or level sensing. Each output has its own arbiter, and each arbiter chooses only among the lines routed to it.

When an output fires, the winning line number is captured and the output stays high until software acknowledges it. To acknowledge, software writes a write-only acknowledge bit in the control word. While the matching output is still high, that write is held with the bus ready signal low. The controller drops the output, then completes the write. Completing the write clears the served line's pending bit and starts a new arbitration round. An output also drops early if its served line stops being pending or is masked. A global mask stops both outputs but keeps latching lines. An active-low status output reports when the mask is in force and both outputs are idle.

The register bus is a single-cycle select/write port with byte addresses and a ready signal. Read data is combinational. Word map: 0x00 control, 0x04 pending, 0x08 software set, 0x0C line mask, 0x10 normal-request winner, 0x14 fast-request winner, and 0x40 + 4*n for the configuration word of line n.

Top module: `fiq_irq_intc`

## Requirements
- R1: After reset, both request outputs are 0, `sec_mask_n` is 1, and the pending, mask and all configuration words read 0. A zero configuration word means priority 0, routed to the normal output, level sensed.
- R2: Writing 1s to the set word (0x08) sets those pending bits, and the set pending bits read back at 0x04. The set word always reads 0.
- R3: A line with configuration bit 0 = 1 is edge sensed. Its pending bit is set only on a 0-to-1 change of its input, so an input held high does not set the bit again after it is cleared.
- R4: A line with configuration bit 0 = 0 is level sensed. Its pending bit is set on every cycle its input is high, so clearing it while the input stays high has no lasting effect.
- R5: Configuration bits [6:2] hold the priority, where a lower value is more urgent. Among equal priorities the lower line number wins. The winner's number reads in bits [4:0] of 0x10 (normal) or 0x14 (fast).
- R6: Configuration bit 1 = 1 routes a line to `fiq_o` and 0 routes it to `irq_o`. The two outputs are arbitrated independently and can be high together. A request rises on the second clock edge after the line is set.
- R7: A request stays high until acknowledged. Acknowledge bit 0 of 0x00 is for the normal output and bit 1 is for the fast output. A write that sets an acknowledge bit while its output is high holds `bus_ready` low for exactly one cycle, during which the output drops. Both acknowledge bits read 0.
- R8: A completed acknowledge clears the served line's pending bit. The next winner on that output rises on the edge after the completed write.
- R9: A raised request drops one edge after its served line's pending bit is cleared through a write-1-to-clear at 0x04, or after the line's bit is set in the mask word at 0x0C.
- R10: While an output's served line has not been acknowledged, no new request is raised on that output, even after the output has dropped. An acknowledge write when the output is already low completes with no stall.
- R11: While global mask bit 2 of 0x00 is 1, lines are still latched but no new request is raised, and `sec_mask_n` is 0 while both outputs are low. Clearing the mask returns `sec_mask_n` to 1, and pending lines are then served.
- R12: Reserved bits read 0 and writes to them are ignored. Writing all 1s to a configuration word reads back 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_ready | output | 1 | Access completes on a clock edge while high |
| irq_lines | input | 32 | Hardware interrupt inputs |
| fiq_o | output | 1 | Fast request output |
| irq_o | output | 1 | Normal request output |
| sec_mask_n | output | 1 | Low when the global mask is set and both outputs are idle |

## Verification
A wrong arbitration result shows within one edge of the request rising, as a wrong number in a winner register. A broken busy/capture state shows as a request that rises again before acknowledge, or that never rises after the acknowledge completes; either is visible two edges after the bus write. Wrong pending bookkeeping shows when the pending word is read back. It also shows when the random service sequence produces a winner order that differs from a priority-then-index ranking computed in the bench. Stall handling errors show directly as a wrong count of ready-low cycles on an acknowledge write.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int WORD_CTRL  = 0;
  localparam int WORD_PEND  = 1;
  localparam int WORD_SET   = 2;
  localparam int WORD_MASK  = 3;
  localparam int WORD_IWIN  = 4;
  localparam int WORD_FWIN  = 5;
  localparam int WORD_LVL0  = 16;

  localparam int CTRL_IACK  = 0;
  localparam int CTRL_FACK  = 1;
  localparam int CTRL_GMASK = 2;

  // a (prio, index) candidate beats the current best when strictly more urgent;
  // ties go to the earlier-scanned, lower index
  function automatic logic prio_beats(input logic have_best, input logic [7:0] p_new,
                                      input logic [7:0] p_best);
    return !have_best || (p_new < p_best);
  endfunction

  // new pending-set event for one line
  function automatic logic line_event(input logic edge_mode, input logic now, input logic prev);
    return edge_mode ? (now & ~prev) : now;
  endfunction
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pending,
  output logic [N-1:0] set_vec
);
  import intc_pkg::*;

  logic [N-1:0] lines_q;
  logic [N-1:0] hw_set;

  for (genvar i = 0; i < N; i++) begin : g_evt
    assign hw_set[i] = line_event(edge_mode[i], lines[i], lines_q[i]);
  end

  assign set_vec = hw_set | sw_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      pending <= '0;
    end else begin
      lines_q <= lines;
      pending <= (pending & ~clr) | set_vec;
    end
  end

  // R2 R3 R4: every set event is latched, set wins over clear
  set_latched_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N      = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                win_valid,
  output logic [IDX_W-1:0]    win_idx
);
  import intc_pkg::*;

  logic [7:0] best_p;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_p    = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && prio_beats(win_valid, 8'(prio_flat[i*PRIO_W +: PRIO_W]), best_p)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best_p    = 8'(prio_flat[i*PRIO_W +: PRIO_W]);
      end
    end
  end

  // R5: a reported winner is always an eligible line
  always_comb begin
    if (win_valid) win_elig_chk: assert (elig[win_idx]);
  end
endmodule

// File: rtl/intc_channel.sv
module intc_channel #(
  parameter int N      = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [N-1:0]     live,
  input  logic             gmask,
  input  logic             ack_req,
  input  logic             ack_commit,
  output logic             req_o,
  output logic             busy,
  output logic [IDX_W-1:0] cap_idx,
  output logic             ack_stall,
  output logic [N-1:0]     ack_clr
);
  logic fire;
  logic drop;

  assign fire      = !busy && win_valid && !gmask;
  assign drop      = busy && (ack_req || !live[cap_idx]);
  assign ack_stall = ack_req && req_o;

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign ack_clr[i] = ack_commit && busy && (cap_idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      busy    <= 1'b0;
      cap_idx <= '0;
    end else if (fire) begin
      req_o   <= 1'b1;
      busy    <= 1'b1;
      cap_idx <= win_idx;
    end else begin
      if (ack_commit) busy <= 1'b0;
      if (drop) req_o <= 1'b0;
    end
  end

  // R10
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> busy);
  // R7
  stall_drops_chk: assert property (@(posedge clk) disable iff (rst)
    ack_stall |=> !req_o);
  // R11
  gmask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (gmask && !busy) |=> !req_o);
  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack_commit) |=> $stable(cap_idx));
endmodule

// File: rtl/fiq_irq_intc.sv
module fiq_irq_intc #(
  parameter int N      = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(N),
  localparam int LVL_W = PRIO_W + 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  input  logic [31:0] irq_lines,
  output logic        fiq_o,
  output logic        irq_o,
  output logic        sec_mask_n
);
  import intc_pkg::*;

  logic [5:0]          word;
  logic                wr_en;
  logic                gmask_q;
  logic [N-1:0]        mask_q;
  logic [PRIO_W-1:0]   prio_q [N];
  logic [N-1:0]        to_fiq;
  logic [N-1:0]        edge_mode;
  logic [N*PRIO_W-1:0] prio_flat;
  logic [N-1:0]        pending, set_vec, sw_set, clr, live;
  logic [N-1:0]        f_clr, i_clr;
  logic                f_valid, i_valid;
  logic [IDX_W-1:0]    f_win, i_win, f_cap, i_cap;
  logic                f_busy, i_busy, f_stall, i_stall;
  logic                ctrl_wr, f_ack_req, i_ack_req;

  assign word      = bus_addr[7:2];
  assign bus_ready = !(f_stall || i_stall);
  assign wr_en     = bus_sel && bus_wr && bus_ready;
  assign ctrl_wr   = bus_sel && bus_wr && (word == 6'(WORD_CTRL));
  assign i_ack_req = ctrl_wr && bus_wdata[CTRL_IACK];
  assign f_ack_req = ctrl_wr && bus_wdata[CTRL_FACK];

  assign sw_set = (wr_en && word == 6'(WORD_SET)) ? bus_wdata[N-1:0] : '0;
  assign clr    = ((wr_en && word == 6'(WORD_PEND)) ? bus_wdata[N-1:0] : '0) | f_clr | i_clr;
  assign live   = pending & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_q <= 1'b0;
      mask_q  <= '0;
    end else if (wr_en) begin
      if (word == 6'(WORD_CTRL)) gmask_q <= bus_wdata[CTRL_GMASK];
      if (word == 6'(WORD_MASK)) mask_q  <= bus_wdata[N-1:0];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_q[i]    <= '0;
        to_fiq[i]    <= 1'b0;
        edge_mode[i] <= 1'b0;
      end else if (wr_en && word == 6'(WORD_LVL0 + i)) begin
        prio_q[i]    <= bus_wdata[LVL_W-1:2];
        to_fiq[i]    <= bus_wdata[1];
        edge_mode[i] <= bus_wdata[0];
      end
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  intc_capture #(.N(N)) u_cap (
    .clk(clk), .rst(rst), .lines(irq_lines[N-1:0]), .edge_mode(edge_mode),
    .sw_set(sw_set), .clr(clr), .pending(pending), .set_vec(set_vec)
  );

  intc_arbiter #(.N(N), .PRIO_W(PRIO_W)) u_arb_f (
    .elig(live & to_fiq), .prio_flat(prio_flat), .win_valid(f_valid), .win_idx(f_win)
  );

  intc_arbiter #(.N(N), .PRIO_W(PRIO_W)) u_arb_i (
    .elig(live & ~to_fiq), .prio_flat(prio_flat), .win_valid(i_valid), .win_idx(i_win)
  );

  intc_channel #(.N(N)) u_ch_f (
    .clk(clk), .rst(rst), .win_valid(f_valid), .win_idx(f_win), .live(live),
    .gmask(gmask_q), .ack_req(f_ack_req), .ack_commit(wr_en && f_ack_req),
    .req_o(fiq_o), .busy(f_busy), .cap_idx(f_cap), .ack_stall(f_stall), .ack_clr(f_clr)
  );

  intc_channel #(.N(N)) u_ch_i (
    .clk(clk), .rst(rst), .win_valid(i_valid), .win_idx(i_win), .live(live),
    .gmask(gmask_q), .ack_req(i_ack_req), .ack_commit(wr_en && i_ack_req),
    .req_o(irq_o), .busy(i_busy), .cap_idx(i_cap), .ack_stall(i_stall), .ack_clr(i_clr)
  );

  assign sec_mask_n = !(gmask_q && !fiq_o && !irq_o);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (word)
        6'(WORD_CTRL): bus_rdata[CTRL_GMASK] = gmask_q;
        6'(WORD_PEND): bus_rdata[N-1:0] = pending;
        6'(WORD_MASK): bus_rdata[N-1:0] = mask_q;
        6'(WORD_IWIN): bus_rdata[IDX_W-1:0] = i_cap;
        6'(WORD_FWIN): bus_rdata[IDX_W-1:0] = f_cap;
        default: begin
          for (int i = 0; i < N; i++)
            if (word == 6'(WORD_LVL0 + i))
              bus_rdata[LVL_W-1:0] = {prio_q[i], to_fiq[i], edge_mode[i]};
        end
      endcase
    end
  end

  // R7: ready is only withheld from a write
  ready_only_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |-> (bus_sel && bus_wr));
  // R7: a stall never lasts past the output dropping
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |=> (bus_ready || !(bus_sel && bus_wr)) || !$stable(bus_addr) || !$stable(bus_wdata));
  // R11: secure status low only when both requests idle
  sec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fiq_o || irq_o) |-> sec_mask_n);
endmodule

// File: tb/tb_fiq_irq_intc.sv
`timescale 1ns/100ps
module tb_fiq_irq_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [31:0] irq_lines = '0;
  logic        fiq_o, irq_o, sec_mask_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fiq_irq_intc dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .irq_lines(irq_lines), .fiq_o(fiq_o), .irq_o(irq_o), .sec_mask_n(sec_mask_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int stalls);
    logic rdy;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; stalls = 0;
    do begin
      #1; rdy = bus_ready;
      if (!rdy) begin stalls++; @(negedge clk); end
    end while (!rdy);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] lvl_addr(input int n);
    return 8'(8'h40 + 4 * n);
  endfunction

  // ranking restated: scan priority levels, then line numbers
  function automatic int exp_win(input logic [31:0] pend, input logic [31:0] fsel,
                                 input logic want_f, input logic [4:0] pr [32]);
    for (int p = 0; p < 32; p++)
      for (int i = 0; i < 32; i++)
        if (pend[i] && fsel[i] == want_f && pr[i] == 5'(p)) return i;
    return -1;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int st;
    logic [4:0]  pr [32];
    logic [31:0] fsel, pend;
    void'($urandom(32'h5eed_1234));

    cyc(3); rst = 1'b0; #1;
    // R1
    chk("R1 fiq", 32'(fiq_o), 0); chk("R1 irq", 32'(irq_o), 0);
    chk("R1 sec", 32'(sec_mask_n), 1);
    rd(8'h04, d); chk("R1 pend", d, 0);
    rd(8'h0C, d); chk("R1 mask", d, 0);
    rd(lvl_addr(17), d); chk("R1 lvl", d, 0);

    // R12
    wr(lvl_addr(0), 32'hFFFF_FFFF, st);
    rd(lvl_addr(0), d); chk("R12 lvl reserved", d, 32'h7F);
    wr(lvl_addr(0), 0, st);
    wr(8'h00, 32'hFFFF_FFF8, st);
    rd(8'h00, d); chk("R12 ctrl reserved", d, 0);

    // R2 R6 R7 R8
    wr(8'h08, 32'h20, st);
    rd(8'h04, d); chk("R2 pend set", d, 32'h20);
    rd(8'h08, d); chk("R2 set reads 0", d, 0);
    chk("R6 irq up", 32'(irq_o), 1); chk("R6 fiq idle", 32'(fiq_o), 0);
    rd(8'h10, d); chk("R5 irq win", d, 5);
    wr(8'h00, 32'h1, st); chk("R7 stall", 32'(st), 1);
    chk("R7 irq low", 32'(irq_o), 0);
    rd(8'h04, d); chk("R8 pend clr", d, 0);
    rd(8'h00, d); chk("R7 ack reads 0", d, 0);

    // R5 priority and tie break
    wr(lvl_addr(3), 32'(4 << 2), st);
    wr(lvl_addr(7), 32'(2 << 2), st);
    wr(lvl_addr(9), 32'(2 << 2), st);
    wr(8'h08, 32'h288, st);
    cyc(1); rd(8'h10, d); chk("R5 first", d, 7);
    wr(8'h00, 1, st); cyc(1); chk("R8 next up", 32'(irq_o), 1);
    rd(8'h10, d); chk("R5 tie", d, 9);
    wr(8'h00, 1, st); cyc(1); rd(8'h10, d); chk("R5 last", d, 3);
    wr(8'h00, 1, st); cyc(2); chk("R8 idle", 32'(irq_o), 0);

    // R6 independent channels
    wr(lvl_addr(4), 32'((9 << 2) | 2), st);
    wr(8'h08, 32'h50, st); cyc(1);
    chk("R6 both fiq", 32'(fiq_o), 1); chk("R6 both irq", 32'(irq_o), 1);
    rd(8'h14, d); chk("R6 fiq win", d, 4);
    rd(8'h10, d); chk("R6 irq win", d, 6);
    wr(8'h00, 3, st); chk("R7 dual stall", 32'(st), 1);
    cyc(2); chk("R7 both low", 32'({fiq_o, irq_o}), 0);

    // R9 R10 clear and mask
    wr(8'h08, 32'h2, st); cyc(1); chk("R9 up", 32'(irq_o), 1);
    wr(8'h04, 32'h2, st); cyc(1); chk("R9 w1c drop", 32'(irq_o), 0);
    wr(8'h08, 32'h1, st); cyc(3); chk("R10 no refire", 32'(irq_o), 0);
    wr(8'h00, 1, st); chk("R10 no stall", 32'(st), 0);
    cyc(1); chk("R10 next served", 32'(irq_o), 1);
    wr(8'h0C, 32'h1, st); cyc(1); chk("R9 mask drop", 32'(irq_o), 0);
    wr(8'h00, 1, st); wr(8'h0C, 0, st); wr(8'h04, 32'hFFFF_FFFF, st);

    // R3 edge line
    wr(lvl_addr(10), 32'h3, st);
    @(negedge clk); irq_lines[10] = 1'b1; cyc(2);
    chk("R3 edge fire", 32'(fiq_o), 1);
    wr(8'h00, 2, st); cyc(3);
    chk("R3 no retrigger", 32'(fiq_o), 0);
    rd(8'h04, d); chk("R3 pend", d, 0);
    @(negedge clk); irq_lines[10] = 1'b0;

    // R4 level line
    @(negedge clk); irq_lines[11] = 1'b1; cyc(2);
    chk("R4 level fire", 32'(irq_o), 1);
    wr(8'h00, 1, st); cyc(1);
    chk("R4 refire", 32'(irq_o), 1);
    rd(8'h04, d); chk("R4 pend held", d, 32'h800);
    @(negedge clk); irq_lines[11] = 1'b0;
    wr(8'h00, 1, st); cyc(2); chk("R4 done", 32'(irq_o), 0);

    // R11 global mask
    wr(8'h00, 4, st); wr(8'h08, 32'h4, st); cyc(3);
    chk("R11 no req", 32'(irq_o), 0); chk("R11 sec low", 32'(sec_mask_n), 0);
    rd(8'h04, d); chk("R11 latched", d, 32'h4);
    wr(8'h00, 0, st); chk("R11 sec high", 32'(sec_mask_n), 1);
    cyc(1); chk("R11 served", 32'(irq_o), 1);
    wr(8'h00, 1, st); cyc(1);

    // random service order, R5 R6 R8
    fsel = '0;
    for (int i = 0; i < 32; i++) begin
      pr[i] = 5'($urandom_range(0, 7));
      fsel[i] = 1'($urandom_range(0, 1));
      wr(lvl_addr(i), {25'd0, pr[i], fsel[i], 1'b0}, st);
    end
    for (int r = 0; r < 20; r++) begin
      d = $urandom;
      wr(8'h08, d, st); pend = d;
      for (int k = 0; k < 40 && pend != 0; k++) begin
        int ef, ei;
        logic [31:0] rf, ri;
        cyc(1);
        ef = exp_win(pend, fsel, 1'b1, pr);
        ei = exp_win(pend, fsel, 1'b0, pr);
        chk("R6 rnd fiq", 32'(fiq_o), 32'(ef >= 0));
        chk("R6 rnd irq", 32'(irq_o), 32'(ei >= 0));
        rd(8'h14, rf); rd(8'h10, ri);
        if (ef >= 0) begin chk("R5 rnd fwin", rf, 32'(ef)); pend[ef] = 1'b0; end
        if (ei >= 0) begin chk("R5 rnd iwin", ri, 32'(ei)); pend[ei] = 1'b0; end
        wr(8'h00, 3, st);
        rd(8'h04, rf); chk("R8 rnd pend", rf, pend);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule